// File: doc/BRIEF.md
# Double-Buffered Four-Channel Compare Timer

This block counts with one or two 12-bit free-running up-counters and watches four compare channels. Each channel has two value registers. A writer loads a staging (preload) value. The compare logic only uses a separate live (active) value. A staged value becomes live at the overflow of the channel's counter, and only if the channel's transfer request is pending. This lets software retune a channel without a glitch in the middle of a counting period.

In single mode, counter 1 drives all four channels and counter 2 is held at zero. In dual mode, counter 1 serves channels 0 and 1, and counter 2 serves channels 2 and 3. Each pair also takes its transfers from the overflow of its own counter. A match latches a per-channel flag that software clears by writing a one. The interrupt line is the level OR of all flags, gated by an enable. A live value of zero disables matching on that channel.

Top module: `cmpu_top`

## Requirements
- R1: Counter 1 counts up by one on each cycle with `run1_i` high and wraps from 0xFFF to 0. `ovf_o[0]` is high during the cycle the counter holds 0xFFF while running. Counter 2 behaves the same way with `run2_i` and `ovf_o[1]`, but only in dual mode. In single mode it is held at 0 and never overflows.
- R2: A channel whose live value is non-zero, and whose source counter equals that value, has its flag set at the next clock edge.
- R3: With `dual_i` low, all four channels compare against counter 1.
- R4: With `dual_i` high, channels 0 and 1 compare against counter 1 and channels 2 and 3 compare against counter 2. Transfers for channels 2 and 3 take place at counter 2's overflow.
- R5: A channel whose live value is zero never sets its flag.
- R6: A write (`wr_en_i` high) stores `wr_data_i` into the staging register of channel `wr_ch_i`. The live value does not change on a write. Reads are combinational. `rd_addr_i[2]` = 0 selects the staging register and 1 selects the live register; `rd_addr_i[1:0]` is the channel.
- R7: A pulse on `xfer_set_i[n]` makes channel n's transfer pending (`xfer_pend_o[n]`). At the edge that ends an overflow cycle of the channel's source counter, a pending channel copies staging into live and its pending bit clears. Without a pending bit, the live value stays as it is across overflows.
- R8: A flag stays set until `flag_clr_i[n]` is high for a cycle. If a match happens in that same cycle, the flag stays set.
- R9: `irq_o` is high exactly while `irq_en_i` is high and at least one flag is set.
- R10: After reset, both counters, all staging and live values, all pending bits, all flags and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run1_i | input | 1 | Count enable, counter 1 |
| run2_i | input | 1 | Count enable, counter 2 (dual mode only) |
| dual_i | input | 1 | 0 = single mode, 1 = dual mode |
| wr_en_i | input | 1 | Staging register write strobe |
| wr_ch_i | input | 2 | Channel written |
| wr_data_i | input | 12 | Value written |
| rd_addr_i | input | 3 | Read select: bit 2 live/staging, bits 1:0 channel |
| rd_data_o | output | 12 | Read data |
| xfer_set_i | input | 4 | Per-channel transfer request pulse |
| flag_clr_i | input | 4 | Per-channel flag clear (write one) |
| irq_en_i | input | 1 | Compare interrupt enable |
| cnt1_o | output | 12 | Counter 1 value |
| cnt2_o | output | 12 | Counter 2 value |
| ovf_o | output | 2 | Overflow pulses, bit 0 counter 1, bit 1 counter 2 |
| xfer_pend_o | output | 4 | Pending transfer bits |
| flag_o | output | 4 | Compare flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The bound checker watches, on every cycle, the counter step and wrap, the flag rising one edge after each match, zero live values never raising a flag, and live values moving only when a pending transfer meets an overflow. It also checks that pending bits drop at that transfer, that clears lose to matches, and that the interrupt gating holds. Only the bench scenarios show that counter routing follows the mode. They do this with two counters offset by 100 cycles, so the counter value seen at the first flag identifies the source. The bench scenarios also cover the staging and live readback encoding, a match at 0xFFF, and a clear landing exactly on a match cycle.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;
  localparam int NUM_CH  = 4;
  localparam int CH_AW   = $clog2(NUM_CH);
  localparam int PAIR_LO = NUM_CH / 2;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_DUAL   = 1'b1
  } cmp_mode_e;

  // Channel uses the second counter only in dual mode and only for the upper pair.
  function automatic logic uses_cnt2(cmp_mode_e mode, int ch);
    return (mode == MODE_DUAL) && (ch >= PAIR_LO);
  endfunction
endpackage

// File: rtl/cmpu_counter.sv
module cmpu_counter #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         hold_zero_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         ld_en;

  always_comb begin
    cnt_d  = cnt_q;
    ld_en  = 1'b0;
    wrap_o = 1'b0;
    if (hold_zero_i) begin
      cnt_d = '0;
      ld_en = 1'b1;
    end else if (en_i) begin
      cnt_d  = cnt_q + W'(1);
      ld_en  = 1'b1;
      wrap_o = (cnt_q == {W{1'b1}});
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cmpu_channel.sv
module cmpu_channel #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         xfer_req_i,
  input  logic         ovf_i,
  input  logic [W-1:0] cnt_i,
  input  logic         clr_i,
  output logic [W-1:0] pre_o,
  output logic [W-1:0] act_o,
  output logic         pend_o,
  output logic         flag_o
);
  logic [W-1:0] pre_q, pre_d, act_q, act_d;
  logic         pend_q, pend_d, flag_q, flag_d;
  logic         hit, do_xfer;

  always_comb begin
    do_xfer = ovf_i & pend_q;
    hit     = (act_q != '0) && (cnt_i == act_q);
    pre_d   = wr_i ? wr_data_i : pre_q;
    act_d   = do_xfer ? pre_q : act_q;
    // a request arriving in the transfer cycle stays pending for the next one
    pend_d  = xfer_req_i | (pend_q & ~ovf_i);
    // a match beats a clear in the same cycle
    flag_d  = hit | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_i)    pre_q <= pre_d;
      if (do_xfer) act_q <= act_d;
      pend_q <= pend_d;
      flag_q <= flag_d;
    end
  end

  assign pre_o  = pre_q;
  assign act_o  = act_q;
  assign pend_o = pend_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/cmpu_top.sv
module cmpu_top
  import cmpu_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run1_i,
  input  logic                 run2_i,
  input  logic                 dual_i,
  input  logic                 wr_en_i,
  input  logic [CH_AW-1:0]     wr_ch_i,
  input  logic [CNT_W-1:0]     wr_data_i,
  input  logic [CH_AW:0]       rd_addr_i,
  output logic [CNT_W-1:0]     rd_data_o,
  input  logic [NUM_CH-1:0]    xfer_set_i,
  input  logic [NUM_CH-1:0]    flag_clr_i,
  input  logic                 irq_en_i,
  output logic [CNT_W-1:0]     cnt1_o,
  output logic [CNT_W-1:0]     cnt2_o,
  output logic [1:0]           ovf_o,
  output logic [NUM_CH-1:0]    xfer_pend_o,
  output logic [NUM_CH-1:0]    flag_o,
  output logic                 irq_o
);
  logic [1:0]                         rst_pipe;
  logic                               rst_sync_n;
  cmp_mode_e                          mode;
  logic [CNT_W-1:0]                   cnt1, cnt2;
  logic                               ovf1, ovf2;
  logic [NUM_CH-1:0][CNT_W-1:0]       pre_arr, act_arr;
  logic [NUM_CH-1:0]                  pend, flag;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign mode = cmp_mode_e'(dual_i);

  cmpu_counter #(.W(CNT_W)) u_cnt1 (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .en_i(run1_i), .hold_zero_i(1'b0),
    .cnt_o(cnt1), .wrap_o(ovf1)
  );

  cmpu_counter #(.W(CNT_W)) u_cnt2 (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .en_i(run2_i),
    .hold_zero_i(mode == MODE_SINGLE),
    .cnt_o(cnt2), .wrap_o(ovf2)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic             sel2;
    logic [CNT_W-1:0] src_cnt;
    logic             src_ovf;

    assign sel2    = uses_cnt2(mode, g);
    assign src_cnt = sel2 ? cnt2 : cnt1;
    assign src_ovf = sel2 ? ovf2 : ovf1;

    cmpu_channel #(.W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_sync_n),
      .wr_i      (wr_en_i && (wr_ch_i == CH_AW'(g))),
      .wr_data_i (wr_data_i),
      .xfer_req_i(xfer_set_i[g]),
      .ovf_i     (src_ovf),
      .cnt_i     (src_cnt),
      .clr_i     (flag_clr_i[g]),
      .pre_o     (pre_arr[g]),
      .act_o     (act_arr[g]),
      .pend_o    (pend[g]),
      .flag_o    (flag[g])
    );
  end

  assign rd_data_o   = rd_addr_i[CH_AW] ? act_arr[rd_addr_i[CH_AW-1:0]]
                                        : pre_arr[rd_addr_i[CH_AW-1:0]];
  assign cnt1_o      = cnt1;
  assign cnt2_o      = cnt2;
  assign ovf_o       = {ovf2, ovf1};
  assign xfer_pend_o = pend;
  assign flag_o      = flag;
  assign irq_o       = irq_en_i & (|flag);
endmodule

// File: rtl/cmpu_checker.sv
module cmpu_checker
  import cmpu_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input logic                           clk_i,
  input logic                           rst_n_i,
  input logic                           dual_i,
  input logic                           run1_i,
  input logic [CNT_W-1:0]               cnt1,
  input logic [CNT_W-1:0]               cnt2,
  input logic [1:0]                     ovf,
  input logic [NUM_CH-1:0][CNT_W-1:0]   pre_arr,
  input logic [NUM_CH-1:0][CNT_W-1:0]   act_arr,
  input logic [NUM_CH-1:0]              pend,
  input logic [NUM_CH-1:0]              flag,
  input logic [NUM_CH-1:0]              xfer_set,
  input logic [NUM_CH-1:0]              flag_clr,
  input logic                           irq_en,
  input logic                           irq
);
  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (run1_i && cnt1 != {CNT_W{1'b1}}) |=> cnt1 == $past(cnt1) + CNT_W'(1));
  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (run1_i && cnt1 == {CNT_W{1'b1}}) |=> cnt1 == '0);
  a_r1_single_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !dual_i |-> !ovf[1]);
  a_r9_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!irq_en || flag == '0) |-> !irq);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    logic             use2;
    logic [CNT_W-1:0] src;
    logic             sovf;
    assign use2 = dual_i && (g >= PAIR_LO);
    assign src  = use2 ? cnt2 : cnt1;
    assign sovf = use2 ? ovf[1] : ovf[0];

    a_r2_match_sets: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (act_arr[g] != '0 && src == act_arr[g]) |=> flag[g]);
    a_r5_zero_silent: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(flag[g]) |-> $past(act_arr[g]) != '0);
    a_r7_copy: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (sovf && pend[g]) |=> act_arr[g] == $past(pre_arr[g]));
    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !(sovf && pend[g]) |=> $stable(act_arr[g]));
    a_r7_pend_drop: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (sovf && pend[g] && !xfer_set[g]) |=> !pend[g]);
    a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (flag_clr[g] && !(act_arr[g] != '0 && src == act_arr[g])) |=> !flag[g]);
  end
endmodule

bind cmpu_top cmpu_checker #(.CNT_W(CNT_W)) u_cmpu_chk (
  .clk_i   (clk_i),
  .rst_n_i (rst_sync_n),
  .dual_i  (dual_i),
  .run1_i  (run1_i),
  .cnt1    (cnt1),
  .cnt2    (cnt2),
  .ovf     (ovf_o),
  .pre_arr (pre_arr),
  .act_arr (act_arr),
  .pend    (pend),
  .flag    (flag),
  .xfer_set(xfer_set_i),
  .flag_clr(flag_clr_i),
  .irq_en  (irq_en_i),
  .irq     (irq_o)
);

// File: tb/cmpu_top_tb_top.sv
module cmpu_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        run1_i, run2_i, dual_i, wr_en_i, irq_en_i;
  logic [1:0]  wr_ch_i;
  logic [11:0] wr_data_i;
  logic [2:0]  rd_addr_i;
  logic [11:0] rd_data_o, cnt1_o, cnt2_o;
  logic [3:0]  xfer_set_i, flag_clr_i, xfer_pend_o, flag_o;
  logic [1:0]  ovf_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  cmpu_top dut_i (.*);

  // vector: {dual, channel[1:0], source_is_cnt2, value[11:0]}
  localparam logic [15:0] VEC [7] = '{
    {1'b0, 2'd0, 1'b0, 12'h010},
    {1'b0, 2'd2, 1'b0, 12'h020},
    {1'b0, 2'd3, 1'b0, 12'h7FF},
    {1'b1, 2'd1, 1'b0, 12'h030},
    {1'b1, 2'd2, 1'b1, 12'h030},
    {1'b1, 2'd3, 1'b1, 12'h005},
    {1'b0, 2'd1, 1'b0, 12'hFFF}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    run1_i = 0; run2_i = 0; dual_i = 0; wr_en_i = 0; irq_en_i = 0;
    wr_ch_i = 0; wr_data_i = 0; rd_addr_i = 0; xfer_set_i = 0; flag_clr_i = 0;
    rst_ni = 0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic write_pre(input int ch, input int val);
    wr_ch_i = 2'(ch); wr_data_i = 12'(val); wr_en_i = 1;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic pulse_xfer(input int ch);
    xfer_set_i = 4'(1 << ch);
    @(negedge clk_i);
    xfer_set_i = 0;
  endtask

  task automatic read_reg(input int addr, output logic [11:0] v);
    rd_addr_i = 3'(addr);
    #1 v = rd_data_o;
  endtask

  task automatic wait_cnt1(input int val);
    for (int k = 0; k < 9000 && cnt1_o != 12'(val); k++) @(negedge clk_i);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] v;
    // ---------------- vector table ----------------
    for (int i = 0; i < 7; i++) begin
      logic        vd, s2, seen_ovf, got;
      int          ch, val;
      logic [11:0] srcv;
      vd = VEC[i][15]; ch = int'(VEC[i][14:13]); s2 = VEC[i][12]; val = int'(VEC[i][11:0]);
      do_reset();
      dual_i = vd;
      write_pre(ch, val);
      pulse_xfer(ch);
      chk(xfer_pend_o == 4'(1 << ch), "R7 pending set", xfer_pend_o, 1 << ch);
      run1_i = 1;
      seen_ovf = 0; got = 0;
      for (int k = 0; k < 3 * 4096 + 300 && !got; k++) begin
        @(negedge clk_i);
        if (k == 100) run2_i = 1;
        if (ovf_o[s2]) seen_ovf = 1;
        if (flag_o != 0) got = 1;
      end
      srcv = s2 ? cnt2_o : cnt1_o;
      // R3 / R4: the counter one step past the value identifies the source
      chk(got && srcv == 12'(val + 1), vd ? "R4 routing" : "R3 routing", srcv, 12'(val + 1));
      chk(flag_o == 4'(1 << ch), "R2 only target flag", flag_o, 1 << ch);
      chk(seen_ovf && xfer_pend_o == 0, "R7 transfer at overflow", xfer_pend_o, 0);
    end

    // ---------------- directed tests ----------------
    do_reset();
    chk(cnt1_o == 0 && cnt2_o == 0 && flag_o == 0 && xfer_pend_o == 0 && !irq_o && ovf_o == 0,
        "R10 reset state", {cnt1_o, flag_o}, 0);
    for (int a = 0; a < 8; a++) begin
      read_reg(a, v);
      chk(v == 0, "R10 reset registers", v, 0);
    end

    write_pre(1, 12'h123);
    read_reg(1, v); chk(v == 12'h123, "R6 staging readback", v, 12'h123);
    read_reg(5, v); chk(v == 0, "R6 live untouched by write", v, 0);

    run1_i = 1;
    wait_cnt1(12'hFFF);
    chk(ovf_o == 2'b01, "R1 overflow pulse", ovf_o, 1);
    @(negedge clk_i);
    chk(cnt1_o == 0 && ovf_o == 0, "R1 wrap to zero", cnt1_o, 0);
    chk(cnt2_o == 0, "R1 counter2 held in single mode", cnt2_o, 0);
    wait_cnt1(12'h200);
    read_reg(5, v); chk(v == 0 && flag_o == 0, "R7 no transfer without request", v, 0);

    pulse_xfer(1);
    wait_cnt1(12'hFFF);
    @(negedge clk_i);
    read_reg(5, v); chk(v == 12'h123 && xfer_pend_o == 0, "R7 transfer and self-clear", v, 12'h123);

    wait_cnt1(12'h124);
    chk(flag_o == 4'b0010 && !irq_o, "R9 flag without enable", {flag_o, irq_o}, 8'h4);
    irq_en_i = 1; #1;
    chk(irq_o, "R9 irq with enable", irq_o, 1);

    @(negedge clk_i);
    flag_clr_i = 4'b0010;
    @(negedge clk_i);
    flag_clr_i = 0;
    chk(flag_o == 0 && !irq_o, "R8 clear", flag_o, 0);

    wait_cnt1(12'h124);
    chk(flag_o == 4'b0010, "R2 flag set again", flag_o, 2);
    wait_cnt1(12'h123);
    flag_clr_i = 4'b0010;
    @(negedge clk_i);
    flag_clr_i = 0;
    chk(flag_o == 4'b0010, "R8 match beats clear", flag_o, 2);

    write_pre(1, 0);
    pulse_xfer(1);
    wait_cnt1(12'hFFF);
    @(negedge clk_i);
    flag_clr_i = 4'b0010;
    @(negedge clk_i);
    flag_clr_i = 0;
    wait_cnt1(12'hFFE);
    chk(flag_o == 0 && !irq_o, "R5 zero value never matches", flag_o, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule